// File: doc/BRIEF.md
# Reverse Bit Scan Execution Unit

This execution unit takes a 16-bit or 32-bit source operand and locates its highest set bit. The search begins at the operand's top bit and moves toward bit 0. It returns that bit's position as an unsigned offset from bit 0, together with a zero flag and a writeback enable for the destination register.

An all-zero source sets the zero flag and drops the writeback enable. In that case the result field carries the destination's previous contents, which the request supplies. A register file behind the unit can therefore either follow the enable or write the result unconditionally, and in both cases the old value survives. This includes the case where destination and source are the same register and it already holds zero.

Requests are qualified by a valid strobe. Each request produces a response exactly one cycle later, and back-to-back requests are accepted every cycle. The carry, overflow and sign outputs are held low. A flag mask tells the consumer that only the zero flag is updated.

Top module: `bsr_unit`

## Requirements
- R1: While reset is held low at a clock edge, every output is zero after that edge, including when a request is presented.
- R2: `rsp_valid` in a cycle equals `req_valid` of the previous cycle, so the latency is one cycle with no gaps.
- R3: For a doubleword request (`req_size`=1) with a non-zero source, `rsp_value` is the offset from bit 0 of the highest set bit of `req_src`.
- R4: For a word request (`req_size`=0), only `req_src[15:0]` is scanned and bits 31:16 have no effect. A word source whose low half is zero is treated as zero, whatever its upper bits hold.
- R5: When the scanned operand is zero, `rsp_zf`=1 and `rsp_wr_en`=0.
- R6: When the scanned operand is zero, `rsp_value` equals the `req_dst_old` of that request.
- R7: When the scanned operand is non-zero, `rsp_zf`=0 and `rsp_wr_en`=1. `rsp_value` is zero-extended: bits 31:5 are zero for a doubleword and bits 31:4 are zero for a word.
- R8: `rsp_cf`, `rsp_of` and `rsp_sf` are always 0. On a valid response, `rsp_flag_mask` is 4'b1000, with bit 0 = carry, bit 1 = overflow, bit 2 = sign and bit 3 = zero. A 1 marks a flag this unit updates.
- R9: In a cycle with `rsp_valid`=0, `rsp_value`, `rsp_wr_en`, `rsp_zf` and `rsp_flag_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_src | input | 32 | Source operand |
| req_size | input | 1 | Operand size: 0 = word, 1 = doubleword |
| req_dst_old | input | 32 | Current destination register contents |
| rsp_valid | output | 1 | Response strobe |
| rsp_value | output | 32 | Bit index, or old destination on zero source |
| rsp_wr_en | output | 1 | Destination writeback enable |
| rsp_zf | output | 1 | Zero flag |
| rsp_cf | output | 1 | Carry flag, always 0 |
| rsp_of | output | 1 | Overflow flag, always 0 |
| rsp_sf | output | 1 | Sign flag, always 0 |
| rsp_flag_mask | output | 4 | Updated-flag mask (bit 3 = zero flag) |

## Verification
Two functions can act on the same request: word-size masking and zero-source preservation. They meet on a word request whose low half is zero and whose upper half holds set bits. The bench sends such requests directly, with every upper-half single bit and with all-ones in the upper half. Random word requests with non-zero upper halves also produce them. Each one is judged as a zero source: the zero flag must be set, writeback must be off, and the value must equal the old destination, never an index taken from the upper bits.

// File: rtl/bsr_pkg.sv
// Package: shared encodings for the reverse bit scan unit.
// Assumes flag-mask bit positions are fixed across the execution cluster.
package bsr_pkg;

    // Operand size select as presented on req_size
    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } opsize_e;

    // Bit positions in the updated-flag mask
    localparam int unsigned FLG_CF = 0;
    localparam int unsigned FLG_OF = 1;
    localparam int unsigned FLG_SF = 2;
    localparam int unsigned FLG_ZF = 3;
    localparam int unsigned FLG_N  = 4;

endpackage

// File: rtl/bsr_group_enc.sv
// Module: bsr_group_enc
// Finds the highest set bit within one small group of bits.
// Assumes GW is a power of two and at least 2.
module bsr_group_enc #(
    parameter int unsigned GW  = 8,
    localparam int unsigned GIW = $clog2(GW)
) (
    input  logic [GW-1:0]  bits,
    output logic           hit,
    output logic [GIW-1:0] idx
);

    // Ascending sweep: the last set bit seen is the highest
    always_comb begin
        hit = |bits;
        idx = '0;
        for (int i = 0; i < GW; i++) begin
            if (bits[i]) begin
                idx = GIW'(i);
            end
        end
    end

endmodule

// File: rtl/bsr_msb_finder.sv
// Module: bsr_msb_finder
// Two-level highest-set-bit search: per-group encoders, then a group selector.
// Assumes W and GW are powers of two with W/GW >= 2.
module bsr_msb_finder #(
    parameter int unsigned W   = 32,
    parameter int unsigned GW  = 8,
    localparam int unsigned NG  = W / GW,
    localparam int unsigned GIW = $clog2(GW),
    localparam int unsigned SIW = $clog2(NG),
    localparam int unsigned IW  = $clog2(W)
) (
    input  logic [W-1:0]  scan,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [NG-1:0]  grp_hit;
    logic [GIW-1:0] grp_idx [NG];
    logic [SIW-1:0] grp_sel;

    // One encoder per group of GW bits
    for (genvar g = 0; g < NG; g++) begin : g_grp
        bsr_group_enc #(.GW(GW)) i_enc (
            .bits (scan[g*GW +: GW]),
            .hit  (grp_hit[g]),
            .idx  (grp_idx[g])
        );
    end

    // Highest group that holds a set bit
    bsr_group_enc #(.GW(NG)) i_sel (
        .bits (grp_hit),
        .hit  (found),
        .idx  (grp_sel)
    );

    // Concatenate the group number with the offset inside it
    always_comb begin
        idx = {grp_sel, grp_idx[grp_sel]};
    end

endmodule

// File: rtl/bsr_operand_gate.sv
// Module: bsr_operand_gate
// Clears the bits above the word size for word-sized requests.
// Assumes WORD_W < W.
module bsr_operand_gate #(
    parameter int unsigned W      = 32,
    parameter int unsigned WORD_W = 16
) (
    input  logic [W-1:0] src,
    input  logic         size,
    output logic [W-1:0] scan
);
    import bsr_pkg::*;

    // Pass the full operand or only its low word
    always_comb begin
        if (size == SZ_DWORD) begin
            scan = src;
        end else begin
            scan = {{(W-WORD_W){1'b0}}, src[WORD_W-1:0]};
        end
    end

endmodule

// File: rtl/bsr_resp_reg.sv
// Module: bsr_resp_reg
// Output stage: registers one response per request, zeroed when idle.
// Assumes synchronous active-low reset.
module bsr_resp_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_value,
    input  logic         in_wr_en,
    input  logic         in_zf,
    output logic         out_valid,
    output logic [W-1:0] out_value,
    output logic         out_wr_en,
    output logic         out_zf
);

    // Capture a response on each request, clear on idle or reset
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_wr_en <= 1'b0;
            out_zf    <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_value <= in_value;
            out_wr_en <= in_wr_en;
            out_zf    <= in_zf;
        end
    end

endmodule

// File: rtl/bsr_unit.sv
// Module: bsr_unit (top)
// Reverse bit scan execution unit with one-cycle registered response.
// A zero scanned operand raises the zero flag, disables writeback and
// returns the old destination value. Assumes DATA_W and GROUP_W are
// powers of two.
module bsr_unit #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned GROUP_W = 8,
    localparam int unsigned IW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_src,
    input  logic              req_size,
    input  logic [DATA_W-1:0] req_dst_old,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_value,
    output logic              rsp_wr_en,
    output logic              rsp_zf,
    output logic              rsp_cf,
    output logic              rsp_of,
    output logic              rsp_sf,
    output logic [3:0]        rsp_flag_mask
);
    import bsr_pkg::*;

    logic [DATA_W-1:0] scan;
    logic              found;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] nxt_value;

    bsr_operand_gate #(.W(DATA_W), .WORD_W(WORD_W)) i_gate (
        .src  (req_src),
        .size (req_size),
        .scan (scan)
    );

    bsr_msb_finder #(.W(DATA_W), .GW(GROUP_W)) i_find (
        .scan  (scan),
        .found (found),
        .idx   (idx)
    );

    // Index when found, otherwise pass the old destination through
    always_comb begin
        nxt_value = found ? DATA_W'(idx) : req_dst_old;
    end

    bsr_resp_reg #(.W(DATA_W)) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_value  (nxt_value),
        .in_wr_en  (found),
        .in_zf     (!found),
        .out_valid (rsp_valid),
        .out_value (rsp_value),
        .out_wr_en (rsp_wr_en),
        .out_zf    (rsp_zf)
    );

    // Flags this unit never computes, and the updated-flag mask
    always_comb begin
        rsp_cf                = 1'b0;
        rsp_of                = 1'b0;
        rsp_sf                = 1'b0;
        rsp_flag_mask         = '0;
        rsp_flag_mask[FLG_ZF] = rsp_valid;
    end

endmodule

// File: rtl/bsr_unit_chk.sv
// Module: bsr_unit_chk
// Property checker for bsr_unit, attached with bind below.
module bsr_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DATA_W-1:0] req_src,
    input logic              req_size,
    input logic [DATA_W-1:0] req_dst_old,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_value,
    input logic              rsp_wr_en,
    input logic              rsp_zf,
    input logic              rsp_cf,
    input logic              rsp_of,
    input logic              rsp_sf,
    input logic [3:0]        rsp_flag_mask
);

    logic src_zero;
    // Scanned operand is zero for the current request
    always_comb begin
        src_zero = req_size ? (req_src == '0) : (req_src[WORD_W-1:0] == '0);
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_dword_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size && req_src != '0) |=>
        (($past(req_src) >> rsp_value) == DATA_W'(1)));
    assert_word_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_size && req_src[WORD_W-1:0] != '0) |=>
        (($past(req_src[WORD_W-1:0]) >> rsp_value) == WORD_W'(1)));
    assert_zero_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && src_zero) |=> (rsp_zf && !rsp_wr_en));
    assert_zero_keeps_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && src_zero) |=> (rsp_value == $past(req_dst_old)));
    assert_found_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_zf) |-> (rsp_wr_en && rsp_value[DATA_W-1:5] == '0));
    assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_flag_mask == 4'b1000 && !rsp_cf && !rsp_of && !rsp_sf));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_value == '0 && !rsp_wr_en && !rsp_zf && rsp_flag_mask == '0));

endmodule

bind bsr_unit bsr_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_bsr_unit_chk (.*);

// File: tb/test_bsr_unit.sv
// Bench for bsr_unit: directed corners plus seeded random requests,
// each compared against a loop reference model.
module test_bsr_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_src;
    logic        req_size;
    logic [31:0] req_dst_old;
    logic        rsp_valid;
    logic [31:0] rsp_value;
    logic        rsp_wr_en;
    logic        rsp_zf;
    logic        rsp_cf;
    logic        rsp_of;
    logic        rsp_sf;
    logic [3:0]  rsp_flag_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsr_unit i_bsr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_size(req_size), .req_dst_old(req_dst_old), .rsp_valid(rsp_valid),
        .rsp_value(rsp_value), .rsp_wr_en(rsp_wr_en), .rsp_zf(rsp_zf),
        .rsp_cf(rsp_cf), .rsp_of(rsp_of), .rsp_sf(rsp_sf),
        .rsp_flag_mask(rsp_flag_mask)
    );

    // Reference: highest set bit over the scanned width, -1 when none
    function automatic int ref_msb(input logic [31:0] s, input logic sz);
        int w = sz ? 32 : 16;
        int r = -1;
        for (int i = 0; i < w; i++) if (s[i]) r = i;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Send one request, then check its response one cycle later
    task automatic run_req(input logic [31:0] s, input logic sz, input logic [31:0] old);
        int m;
        logic [31:0] ev;
        req_valid = 1'b1; req_src = s; req_size = sz; req_dst_old = old;
        @(negedge clk);
        m  = ref_msb(s, sz);
        ev = (m < 0) ? old : 32'(m);
        check(rsp_valid == 1'b1, "R2 valid", 64'(rsp_valid), 64'd1);
        if (m < 0) begin
            check(rsp_zf && !rsp_wr_en, "R5 zero flags",
                  {rsp_zf, rsp_wr_en}, 64'b10);
            check(rsp_value == ev, "R6 old dest kept", rsp_value, ev);
        end else begin
            check(!rsp_zf && rsp_wr_en, "R7 found flags",
                  {rsp_zf, rsp_wr_en}, 64'b01);
            check(rsp_value == ev, sz ? "R3 dword index" : "R4 word index",
                  rsp_value, ev);
        end
        check({rsp_cf, rsp_of, rsp_sf} == 3'b000 && rsp_flag_mask == 4'b1000,
              "R8 flags/mask", {rsp_cf, rsp_of, rsp_sf, rsp_flag_mask},
              {3'b000, 4'b1000});
    endtask

    task automatic idle_check();
        req_valid = 1'b0; req_src = $urandom; req_dst_old = $urandom;
        @(negedge clk);
        check(!rsp_valid, "R2 no request", 64'(rsp_valid), 64'd0);
        check(rsp_value == 0 && !rsp_wr_en && !rsp_zf && rsp_flag_mask == 0,
              "R9 idle outputs", {rsp_value, rsp_wr_en, rsp_zf, rsp_flag_mask}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_valid = 1'b1; req_src = 32'hFFFF_FFFF;
        req_size = 1'b1; req_dst_old = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        // R1: request held during reset produces nothing
        check(!rsp_valid && rsp_value == 0 && !rsp_wr_en && !rsp_zf && rsp_flag_mask == 0,
              "R1 reset state", {rsp_valid, rsp_value, rsp_wr_en, rsp_zf}, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        idle_check();

        // Every single bit, both sizes (upper word bits in word mode: R4 + R6)
        for (int i = 0; i < 32; i++) run_req(32'd1 << i, 1'b1, 32'hA5A5_0000 | i);
        for (int i = 0; i < 32; i++) run_req(32'd1 << i, 1'b0, 32'h5A5A_0000 | i);
        // All-ones and all-zero, both sizes
        run_req(32'hFFFF_FFFF, 1'b1, 32'h1111_1111);
        run_req(32'hFFFF_FFFF, 1'b0, 32'h2222_2222);
        run_req(32'h0000_0000, 1'b1, 32'h3333_3333);
        run_req(32'h0000_0000, 1'b0, 32'h4444_4444);
        // Same-register case: destination already zero and source zero
        run_req(32'h0000_0000, 1'b1, 32'h0000_0000);
        // R4: upper half full, low half zero, in word mode
        run_req(32'hFFFF_0000, 1'b0, 32'h7777_7777);
        idle_check();

        // Random mix, with occasional idle gaps and forced zero low words
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] s = $urandom;
            int sh = $urandom_range(0, 31);
            case ($urandom_range(0, 3))
                0: s = s >> sh;
                1: s = s & 32'hFFFF_0000;
                default: ;
            endcase
            if ($urandom_range(0, 9) == 0) idle_check();
            run_req(s, 1'($urandom_range(0, 1)), $urandom);
        end
        idle_check();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule